// File: doc/BRIEF.md
# Multicore Reset Control Registers

This block is the register bank that steers start-up and reset of a four-core cluster. Software reaches it through a word-addressed read/write port with a 4 KiB byte window. Sixteen 32-bit registers sit at the bottom of that window. Index 0 is a control word. The other registers are a reset-status word, an interrupt status and mask pair, two boot-mode words, and ten general-purpose words, GP1 to GP10, at indices 6 to 15.

A write to the control word does not act on the value written. It acts on the bits that changed: the old stored word is XORed with the new one. A changed core enable bit produces a one-cycle power-up or power-down request to that core. A power-up request also presents a start address and a context word, read from a fixed pair of general-purpose registers. A changed core reset bit produces a one-cycle reset request. That bit then stays set until the core returns a completion strobe. Two peripheral soft-reset bits clear themselves as soon as they change.

The request port is valid/ready with `bus_ready` held high. The block never applies back-pressure, so every cycle with `bus_valid` high is one accepted access. A read answers in the next cycle with `rsp_valid` high for one cycle. The response side has no ready, so the requester must accept the data in that cycle.

Top module: `mcore_rst_regs`

## Requirements
- R1: After reset, these registers hold these values:
  - control word (index 0): 0x521
  - reset-status word (index 2): 0x1
  - interrupt mask (index 4): 0x1F
  - every other register: 0
- R2: An accepted access selects register index `bus_addr[11:2]`. The bus is always ready (`bus_ready`=1). A read returns the register value on `rsp_rdata`, with `rsp_valid`=1, in the cycle after acceptance.
- R3: Some accesses do not decode: an index of 16 or more, or a nonzero `bus_addr[1:0]`. Such a read returns 0, and such a write changes no register and raises no request.
- R4: A write to any register other than the control word stores the written value unchanged.
- R5: Bit 21+c of the control word is the enable for core c, for c = 1..3. A write that changes this bit pulses a request for one cycle, in the cycle after acceptance:
  - new value 1: a power-up pulse on `pwr_on_req[c]`, with `core_entry` lane c set to GP(2c+1) and `core_ctx` lane c set to GP(2c+2). Lane c is bits 32c+31:32c.
  - new value 0: a power-down pulse on `pwr_off_req[c]`.
- R6: Bit 13+c of the control word is the reset bit for core c, for c = 0..3. A write that changes this bit pulses `rst_req[c]` for one cycle, in the cycle after acceptance. The exception is a write that also changes the enable bit of the same core: that write raises no reset pulse.
- R7: A core reset bit keeps its stored value until `core_done[c]` is sampled high. That edge clears the bit. If a control write is accepted at the same edge, the clear is applied on top of the written value.
- R8: Control bits 3 and 12 are soft-reset bits. A write that changes either one stores 0 there, so it reads back as 0 at once.
- R9: A control write that changes no enable bit or reset bit raises no request pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_valid | input | 1 | Access request valid |
| bus_ready | output | 1 | Always 1; every valid access is accepted |
| bus_write | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 12 | Byte address within the 4 KiB window |
| bus_wdata | input | 32 | Write data |
| rsp_valid | output | 1 | Read data valid, one cycle after an accepted read |
| rsp_rdata | output | 32 | Read data |
| core_done | input | 4 | Per-core reset-completion strobe |
| pwr_on_req | output | 4 | Per-core power-up pulse (bit 0 is always 0) |
| pwr_off_req | output | 4 | Per-core power-down pulse (bit 0 is always 0) |
| rst_req | output | 4 | Per-core reset pulse |
| core_entry | output | 128 | Per-core start address, 32 bits per core, loaded on power-up |
| core_ctx | output | 128 | Per-core context word, 32 bits per core, loaded on power-up |

## Verification
The control word is driven with several kinds of write, each chosen so that its expected pulses differ from the others:
- setting an enable bit alone, which must give a power-up pulse with the right address pair;
- clearing an enable bit, which must give a power-down pulse;
- setting a reset bit alone, which must give a reset pulse;
- changing an enable bit and the reset bit of the same core together, where the reset pulse must be suppressed;
- rewriting the stored word unchanged, which must give no pulse at all.

The completion strobe is applied once on its own and once at the same edge as a control write, to show that the clear is applied after the write. Misaligned and out-of-range accesses are followed by read-backs that show no register moved.

// File: rtl/mcr_pkg.sv
package mcr_pkg;
  localparam int unsigned DW          = 32;
  localparam int unsigned NREG        = 16;
  localparam int unsigned IDX_CTRL    = 0;
  localparam int unsigned IDX_RSTAT   = 2;
  localparam int unsigned IDX_IMASK   = 4;
  localparam int unsigned IDX_GP_BASE = 5;   // GPk lives at index 5+k
  localparam logic [DW-1:0] CTRL_INIT  = 32'h0000_0521;
  localparam logic [DW-1:0] RSTAT_INIT = 32'h0000_0001;
  localparam logic [DW-1:0] IMASK_INIT = 32'h0000_001F;
  localparam int unsigned RST_LSB  = 13;
  localparam int unsigned EN_LSB   = 21;
  localparam int unsigned SOFT_A   = 3;
  localparam int unsigned SOFT_B   = 12;

  function automatic int unsigned entry_idx(int unsigned core);
    return IDX_GP_BASE + 2*core + 1;
  endfunction

  function automatic int unsigned ctx_idx(int unsigned core);
    return IDX_GP_BASE + 2*core + 2;
  endfunction

  function automatic logic [DW-1:0] init_value(int unsigned idx);
    case (idx)
      IDX_CTRL:  return CTRL_INIT;
      IDX_RSTAT: return RSTAT_INIT;
      IDX_IMASK: return IMASK_INIT;
      default:   return '0;
    endcase
  endfunction
endpackage

// File: rtl/mcr_addr_dec.sv
module mcr_addr_dec #(
  parameter int unsigned AW   = 12,
  parameter int unsigned NREG = 16,
  localparam int unsigned IW  = $clog2(NREG)
) (
  input  logic [AW-1:0] addr,
  output logic          hit,
  output logic [IW-1:0] idx
);
  logic [AW-3:0] word;
  assign word = addr[AW-1:2];
  assign hit  = (addr[1:0] == 2'b00) && (int'(word) < int'(NREG));
  assign idx  = word[IW-1:0];
endmodule

// File: rtl/mcr_ctrl_eval.sv
module mcr_ctrl_eval
  import mcr_pkg::*;
#(
  parameter int unsigned NCORE = 4
) (
  input  logic [DW-1:0]    cur,
  input  logic [DW-1:0]    wdata,
  input  logic             wr,
  input  logic [NCORE-1:0] done,
  output logic [DW-1:0]    nxt,
  output logic [NCORE-1:0] on,
  output logic [NCORE-1:0] off,
  output logic [NCORE-1:0] rst
);
  logic [DW-1:0]    chg;
  logic [DW-1:0]    staged;
  logic [NCORE-1:0] en_chg;

  assign chg = wr ? (cur ^ wdata) : '0;

  genvar c;
  generate
    for (c = 0; c < NCORE; c++) begin : g_core
      if (c == 0) begin : g_nopwr
        assign en_chg[c] = 1'b0;
      end else begin : g_pwr
        assign en_chg[c] = chg[EN_LSB + c];
      end
      assign on[c]  = en_chg[c] &  wdata[EN_LSB + c];
      assign off[c] = en_chg[c] & ~wdata[EN_LSB + c];
      assign rst[c] = chg[RST_LSB + c] & ~en_chg[c];
    end
  endgenerate

  always_comb begin
    staged = wr ? wdata : cur;
    if (chg[SOFT_A]) staged[SOFT_A] = 1'b0;
    if (chg[SOFT_B]) staged[SOFT_B] = 1'b0;
    for (int k = 0; k < int'(NCORE); k++) begin
      if (done[k]) staged[RST_LSB + k] = 1'b0;
    end
    nxt = staged;
  end
endmodule

// File: rtl/mcr_boot_latch.sv
module mcr_boot_latch #(
  parameter int unsigned DW = 32
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          load,
  input  logic [DW-1:0] entry_in,
  input  logic [DW-1:0] ctx_in,
  output logic [DW-1:0] entry_q,
  output logic [DW-1:0] ctx_q
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      entry_q <= '0;
      ctx_q   <= '0;
    end else if (load) begin
      entry_q <= entry_in;
      ctx_q   <= ctx_in;
    end
  end
endmodule

// File: rtl/mcore_rst_regs.sv
module mcore_rst_regs
  import mcr_pkg::*;
#(
  parameter int unsigned NCORE = 4,
  parameter int unsigned AW    = 12
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                bus_valid,
  output logic                bus_ready,
  input  logic                bus_write,
  input  logic [AW-1:0]       bus_addr,
  input  logic [DW-1:0]       bus_wdata,
  output logic                rsp_valid,
  output logic [DW-1:0]       rsp_rdata,
  input  logic [NCORE-1:0]    core_done,
  output logic [NCORE-1:0]    pwr_on_req,
  output logic [NCORE-1:0]    pwr_off_req,
  output logic [NCORE-1:0]    rst_req,
  output logic [NCORE*DW-1:0] core_entry,
  output logic [NCORE*DW-1:0] core_ctx
);
  localparam int unsigned IW = $clog2(NREG);

  logic [DW-1:0]    regs [NREG];
  logic [DW-1:0]    ctrl_q;
  logic [DW-1:0]    ctrl_nxt;
  logic             hit;
  logic [IW-1:0]    idx;
  logic             wr_ok;
  logic             wr_ctrl;
  logic [NCORE-1:0] on_nxt, off_nxt, rst_nxt;

  assign bus_ready = 1'b1;
  assign ctrl_q    = regs[IDX_CTRL];

  mcr_addr_dec #(.AW(AW), .NREG(NREG)) u_dec (
    .addr(bus_addr), .hit(hit), .idx(idx)
  );

  assign wr_ok   = bus_valid && bus_write && hit;
  assign wr_ctrl = wr_ok && (int'(idx) == int'(IDX_CTRL));

  mcr_ctrl_eval #(.NCORE(NCORE)) u_eval (
    .cur(ctrl_q), .wdata(bus_wdata), .wr(wr_ctrl), .done(core_done),
    .nxt(ctrl_nxt), .on(on_nxt), .off(off_nxt), .rst(rst_nxt)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < int'(NREG); i++) regs[i] <= init_value(i);
    end else begin
      for (int i = 0; i < int'(NREG); i++) begin
        if (i == int'(IDX_CTRL)) regs[i] <= ctrl_nxt;
        else if (wr_ok && int'(idx) == i) regs[i] <= bus_wdata;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rsp_valid   <= 1'b0;
      rsp_rdata   <= '0;
      pwr_on_req  <= '0;
      pwr_off_req <= '0;
      rst_req     <= '0;
    end else begin
      rsp_valid   <= bus_valid && !bus_write;
      if (bus_valid && !bus_write) rsp_rdata <= hit ? regs[idx] : '0;
      pwr_on_req  <= on_nxt;
      pwr_off_req <= off_nxt;
      rst_req     <= rst_nxt;
    end
  end

  genvar c;
  generate
    for (c = 0; c < NCORE; c++) begin : g_boot
      if (c == 0) begin : g_none
        assign core_entry[c*DW +: DW] = '0;
        assign core_ctx[c*DW +: DW]   = '0;
      end else begin : g_lat
        mcr_boot_latch #(.DW(DW)) u_lat (
          .clk(clk), .rst_n(rst_n), .load(on_nxt[c]),
          .entry_in(regs[entry_idx(c)]), .ctx_in(regs[ctx_idx(c)]),
          .entry_q(core_entry[c*DW +: DW]), .ctx_q(core_ctx[c*DW +: DW])
        );
      end
    end
  endgenerate
endmodule

// File: rtl/mcr_checker.sv
module mcr_checker
  import mcr_pkg::*;
#(
  parameter int unsigned NCORE = 4,
  parameter int unsigned AW    = 12
) (
  input logic             clk,
  input logic             rst_n,
  input logic             bus_valid,
  input logic             bus_write,
  input logic [AW-1:0]    bus_addr,
  input logic [DW-1:0]    bus_wdata,
  input logic [NCORE-1:0] core_done,
  input logic [NCORE-1:0] pwr_on_req,
  input logic [NCORE-1:0] pwr_off_req,
  input logic [NCORE-1:0] rst_req,
  input logic [DW-1:0]    ctrl_q
);
  logic ctrl_wr, bad_wr;
  assign ctrl_wr = bus_valid && bus_write && (bus_addr == '0);
  assign bad_wr  = bus_valid && bus_write &&
                   ((bus_addr[1:0] != 2'b00) || (int'(bus_addr[AW-1:2]) >= int'(NREG)));

  // R5/R6: requests only follow an accepted write
  a_r5_req_after_write: assert property (@(posedge clk) disable iff (!rst_n)
    ((pwr_on_req | pwr_off_req | rst_req) != '0) |-> $past(bus_valid && bus_write));

  a_r5_on_off_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
    (pwr_on_req & pwr_off_req) == '0);

  a_r8_soft_clear: assert property (@(posedge clk) disable iff (!rst_n)
    (ctrl_wr && (ctrl_q[SOFT_A] != bus_wdata[SOFT_A])) |=> !ctrl_q[SOFT_A]);

  a_r3_bad_write_ignored: assert property (@(posedge clk) disable iff (!rst_n)
    (bad_wr && core_done == '0) |=> $stable(ctrl_q));

  genvar c;
  generate
    for (c = 0; c < NCORE; c++) begin : g_c
      a_r7_done_clears: assert property (@(posedge clk) disable iff (!rst_n)
        core_done[c] |=> !ctrl_q[RST_LSB + c]);
      if (c > 0) begin : g_en
        a_r6_enable_masks_reset: assert property (@(posedge clk) disable iff (!rst_n)
          (ctrl_wr && (ctrl_q[EN_LSB + c] != bus_wdata[EN_LSB + c])) |=> !rst_req[c]);
      end
    end
  endgenerate
endmodule

bind mcore_rst_regs mcr_checker #(.NCORE(NCORE), .AW(AW)) u_chk (
  .clk(clk), .rst_n(rst_n), .bus_valid(bus_valid), .bus_write(bus_write),
  .bus_addr(bus_addr), .bus_wdata(bus_wdata), .core_done(core_done),
  .pwr_on_req(pwr_on_req), .pwr_off_req(pwr_off_req), .rst_req(rst_req),
  .ctrl_q(ctrl_q)
);

// File: tb/mcore_rst_regs_test.sv
module mcore_rst_regs_test;
  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         bus_valid = 1'b0;
  logic         bus_ready;
  logic         bus_write = 1'b0;
  logic [11:0]  bus_addr = '0;
  logic [31:0]  bus_wdata = '0;
  logic         rsp_valid;
  logic [31:0]  rsp_rdata;
  logic [3:0]   core_done = '0;
  logic [3:0]   pwr_on_req, pwr_off_req, rst_req;
  logic [127:0] core_entry, core_ctx;

  int total = 0;
  int fails = 0;
  logic [31:0] ec;
  logic [3:0]  c_on, c_off, c_rst;
  logic [127:0] c_entry, c_ctx;
  bit finished = 0;

  always #5 clk = ~clk;

  mcore_rst_regs uut (
    .clk(clk), .rst_n(rst_n), .bus_valid(bus_valid), .bus_ready(bus_ready),
    .bus_write(bus_write), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
    .rsp_valid(rsp_valid), .rsp_rdata(rsp_rdata), .core_done(core_done),
    .pwr_on_req(pwr_on_req), .pwr_off_req(pwr_off_req), .rst_req(rst_req),
    .core_entry(core_entry), .core_ctx(core_ctx)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [11:0] a, input logic [31:0] d, input logic [3:0] dn);
    @(negedge clk);
    bus_valid = 1; bus_write = 1; bus_addr = a; bus_wdata = d; core_done = dn;
    @(negedge clk);
    c_on = pwr_on_req; c_off = pwr_off_req; c_rst = rst_req;
    c_entry = core_entry; c_ctx = core_ctx;
    bus_valid = 0; bus_write = 0; core_done = '0;
  endtask

  task automatic rd(input logic [11:0] a, output logic [31:0] d);
    @(negedge clk);
    bus_valid = 1; bus_write = 0; bus_addr = a;
    @(negedge clk);
    d = rsp_rdata;
    chk("R2 rsp_valid", {31'd0, rsp_valid}, 32'd1);
    bus_valid = 0;
  endtask

  task automatic pulse_done(input logic [3:0] m);
    @(negedge clk); core_done = m;
    @(negedge clk); core_done = '0;
  endtask

  task automatic chk_pulses(input string tag, input logic [3:0] on, input logic [3:0] off,
                            input logic [3:0] rs);
    chk({tag, " on"},  {28'd0, c_on},  {28'd0, on});
    chk({tag, " off"}, {28'd0, c_off}, {28'd0, off});
    chk({tag, " rst"}, {28'd0, c_rst}, {28'd0, rs});
  endtask

  task automatic t_reset();
    logic [31:0] v;
    chk("R2 ready", {31'd0, bus_ready}, 32'd1);
    rd(12'h000, v); chk("R1 ctrl", v, 32'h521);
    rd(12'h008, v); chk("R1 rstat", v, 32'h1);
    rd(12'h010, v); chk("R1 imask", v, 32'h1F);
    rd(12'h018, v); chk("R1 gp1", v, 32'h0);
    rd(12'h03C, v); chk("R1 gp10", v, 32'h0);
  endtask

  task automatic t_gp_store();
    logic [31:0] v;
    for (int k = 3; k <= 8; k++) wr(12'(4*(5+k)), 32'h1000_0000 + 32'(k), 4'b0);
    wr(12'h00C, 32'hA5A5_0F0F, 4'b0);
    rd(12'h020, v); chk("R4 gp3", v, 32'h1000_0003);
    rd(12'h034, v); chk("R4 gp8", v, 32'h1000_0008);
    rd(12'h00C, v); chk("R4 intstat", v, 32'hA5A5_0F0F);
  endtask

  task automatic t_unmapped();
    logic [31:0] v;
    wr(12'h040, 32'hFFFF_FFFF, 4'b0);
    rd(12'h040, v); chk("R3 read idx16", v, 32'h0);
    rd(12'hFFC, v); chk("R3 read top", v, 32'h0);
    wr(12'h022, 32'hDEAD_BEEF, 4'b0);
    rd(12'h020, v); chk("R3 misaligned write", v, 32'h1000_0003);
    wr(12'h001, 32'hFFFF_FFFF, 4'b0);
    chk_pulses("R3 misaligned ctrl", 4'b0, 4'b0, 4'b0);
    rd(12'h000, v); chk("R3 ctrl kept", v, ec);
  endtask

  task automatic t_power_on();
    ec = ec | (32'd1 << 22);
    wr(12'h000, ec, 4'b0);
    chk_pulses("R5 core1 up", 4'b0010, 4'b0, 4'b0);
    chk("R5 entry1", c_entry[63:32], 32'h1000_0003);
    chk("R5 ctx1", c_ctx[63:32], 32'h1000_0004);
    @(negedge clk);
    chk("R5 one cycle", {28'd0, pwr_on_req}, 32'd0);
  endtask

  task automatic t_reset_done();
    logic [31:0] v;
    ec = ec | (32'd1 << 14);
    wr(12'h000, ec, 4'b0);
    chk_pulses("R6 core1 reset", 4'b0, 4'b0, 4'b0010);
    rd(12'h000, v); chk("R7 held", v, ec);
    pulse_done(4'b0010);
    ec = ec & ~(32'd1 << 14);
    rd(12'h000, v); chk("R7 cleared", v, ec);
    ec = ec | (32'd1 << 13);
    wr(12'h000, ec, 4'b0);
    chk_pulses("R6 core0 reset", 4'b0, 4'b0, 4'b0001);
    pulse_done(4'b0001);
    ec = ec & ~(32'd1 << 13);
  endtask

  task automatic t_enable_masks_reset();
    logic [31:0] v;
    ec = ec | (32'd1 << 23) | (32'd1 << 15);
    wr(12'h000, ec, 4'b0);
    chk_pulses("R6 core2 masked", 4'b0100, 4'b0, 4'b0);
    chk("R5 entry2", c_entry[95:64], 32'h1000_0005);
    rd(12'h000, v); chk("R7 core2 held", v, ec);
    pulse_done(4'b0100);
    ec = ec & ~(32'd1 << 15);
    rd(12'h000, v); chk("R7 core2 cleared", v, ec);
  endtask

  task automatic t_power_off();
    ec = ec & ~(32'd1 << 22);
    wr(12'h000, ec, 4'b0);
    chk_pulses("R5 core1 down", 4'b0, 4'b0010, 4'b0);
  endtask

  task automatic t_done_with_write();
    logic [31:0] v;
    wr(12'h000, ec | (32'd1 << 16), 4'b1000);
    chk_pulses("R6 core3 reset", 4'b0, 4'b0, 4'b1000);
    rd(12'h000, v); chk("R7 done after write", v, ec);
  endtask

  task automatic t_soft_bits();
    logic [31:0] v;
    wr(12'h000, ec | (32'd1 << 3) | (32'd1 << 12), 4'b0);
    chk_pulses("R8 no req", 4'b0, 4'b0, 4'b0);
    rd(12'h000, v); chk("R8 soft bits zero", v, ec);
  endtask

  task automatic t_no_change();
    wr(12'h000, ec, 4'b0);
    chk_pulses("R9 same value", 4'b0, 4'b0, 4'b0);
  endtask

  initial begin
    ec = 32'h521;
    repeat (3) @(negedge clk);
    rst_n = 1;
    t_reset();
    t_gp_store();
    t_unmapped();
    t_power_on();
    t_reset_done();
    t_enable_masks_reset();
    t_power_off();
    t_done_with_write();
    t_soft_bits();
    t_no_change();
    finished = 1;
    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end

  initial begin
    #1_000_000;
    if (!finished) begin
      total++; fails++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("%0d/%0d checks passed", total - fails, total);
      $finish;
    end
  end
endmodule